// File: doc/BRIEF.md
# Dead-Block Victim and Bypass Selector

This block is the replacement decision logic for a set-associative cache that tracks one dead-prediction bit per line. It holds the valid bits, the dead bits and the recency order of every way of every set. A separate predictor says whether the block being accessed is expected to see no further reuse. For each access it produces a single decision: bypass the block, allocate a given way, or, on a hit, refresh that line's metadata.

On a miss, a block that is predicted dead is never inserted. Otherwise the selector fills an empty way if one exists. If the set is full it reuses a line already marked dead. Only when neither is available does it fall back to a default policy. That default is least-recently-used order or a pseudo-random way, chosen by a mode input. On a hit, the current prediction is written into the hit line's dead bit and the line becomes most recently used.

Each request is accepted in one cycle. The decision is registered and appears on the following cycle. The state for that access is updated at the same clock edge.

Top module: `deadblk_repl`

## Requirements
- R1: Every cycle with `req_valid` high produces exactly one response with `rsp_valid` high on the next cycle. A cycle without a request produces no response.
- R2: On a miss with `pred_dead` low, the victim is the lowest-numbered invalid way of the addressed set, if the set has any invalid way.
- R3: On a miss with `pred_dead` low in a full set, the victim is the lowest-numbered way whose dead bit is set, if any. This choice takes precedence over the default policy.
- R4: On a miss with `pred_dead` high, the response has `rsp_bypass`=1, `rsp_alloc`=0 and `rsp_way`=0. The valid bits, dead bits and recency order of every set stay unchanged.
- R5: An allocated way becomes valid and has its dead bit cleared. It becomes the most recently used way of its set. The response has `rsp_alloc`=1 and `rsp_way` equal to the victim.
- R6: On a hit (`req_hit`=1) to `req_way`, that line's dead bit is set equal to `pred_dead` and the line becomes most recently used. The response has `rsp_alloc`=0, `rsp_bypass`=0 and `rsp_way`=0.
- R7: With `mode_rand`=0, a full set with no dead line evicts its least recently used way. After reset the recency order follows the way number: way 0 is the most recent and the highest way is the least recent.
- R8: With `mode_rand`=1, a full set with no dead line evicts the way given by the low log2(WAYS) bits of a 16-bit LFSR. The LFSR resets to 0xACE1. It steps to `{s[14:0], s[15]^s[13]^s[12]^s[10]}` once per miss (bypassed or not) and never on a hit or an idle cycle. The victim uses the value before the step.
- R9: A request to one set changes no valid bit, dead bit or recency state of any other set.
- R10: After reset, `rsp_valid` is 0 and every way of every set is invalid with its dead bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_rand | input | 1 | Default policy: 0 = least recently used, 1 = pseudo-random |
| req_valid | input | 1 | Access request present this cycle |
| req_hit | input | 1 | 1 = the access hit `req_way`, 0 = miss |
| req_set | input | $clog2(SETS) | Addressed set |
| req_way | input | $clog2(WAYS) | Hit way (used only when `req_hit`=1) |
| pred_dead | input | 1 | Predictor says the accessed block is dead |
| rsp_valid | output | 1 | Decision for the previous cycle's request |
| rsp_bypass | output | 1 | Miss block is not inserted |
| rsp_alloc | output | 1 | Miss block is inserted into `rsp_way` |
| rsp_way | output | $clog2(WAYS) | Victim way when `rsp_alloc`=1, otherwise 0 |

## Verification
The bench builds the block with its defaults: four sets of sixteen ways. With sixteen ways a single set can be filled way by way to cover the whole invalid-first order. The 4-bit random index then spans every way. Four sets are enough to show that traffic to one set leaves another untouched. A long mixed phase switches between the two default modes and hits ways that it marks dead and then alive again. This drives the dead-over-default priority and the rule that a bypass leaves every piece of state unchanged. The LFSR sequence runs long enough that random victims repeat and collide with dead ways.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    // One step of the replacement LFSR (shift toward MSB, feedback into bit 0)
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // Kind of access being handled this cycle
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_HIT    = 2'd1,
        OP_FILL   = 2'd2,
        OP_BYPASS = 2'd3
    } op_e;

    // Reason a victim was chosen
    typedef enum logic [1:0] {
        SRC_EMPTY = 2'd0,
        SRC_DEAD  = 2'd1,
        SRC_LRU   = 2'd2,
        SRC_RAND  = 2'd3
    } vsrc_e;

endpackage

// File: rtl/dbr_first_one.sv
module dbr_first_one #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Lowest set bit wins: scan from the top so lower indices overwrite
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dbr_lfsr.sv
module dbr_lfsr
    import dbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [LFSR_W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LFSR_SEED;
        end else if (step) begin
            state <= lfsr_step(state);
        end
    end

    a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    a_r8_lfsr_holds: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(state));
endmodule

// File: rtl/dbr_lru_ranks.sv
module dbr_lru_ranks #(
    parameter int SETS = 4,
    parameter int WAYS = 16,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] rd_set,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] lru_way
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    // Rank 0 = most recent, WAYS-1 = least recent; ranks of a set form a permutation
    logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] rank_q;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int v = 0; v < WAYS; v++) begin
                    rank_q[s][v] <= WAY_W'(v);
                end
            end else if (touch_en && touch_set == SET_W'(s)) begin
                for (int v = 0; v < WAYS; v++) begin
                    if (WAY_W'(v) == touch_way) begin
                        rank_q[s][v] <= '0;
                    end else if (rank_q[s][v] < rank_q[s][touch_way]) begin
                        rank_q[s][v] <= rank_q[s][v] + 1'b1;
                    end
                end
            end
        end
    end

    logic [WAYS-1:0] is_oldest;
    logic            oldest_found;

    always_comb begin
        for (int v = 0; v < WAYS; v++) begin
            is_oldest[v] = (rank_q[rd_set][v] == OLDEST);
        end
    end

    dbr_first_one #(.N(WAYS)) u_oldest (
        .vec   (is_oldest),
        .found (oldest_found),
        .idx   (lru_way)
    );

    // R7: exactly one way of the looked-up set holds the oldest rank
    a_r7_single_oldest: assert property (@(posedge clk) disable iff (rst)
        $onehot(is_oldest) && oldest_found);

    // R7: a touched way is most recent afterwards
    a_r7_touch_mru: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> rank_q[$past(touch_set)][$past(touch_way)] == '0);
endmodule

// File: rtl/deadblk_repl.sv
module deadblk_repl
    import dbr_pkg::*;
#(
    parameter int SETS = 4,
    parameter int WAYS = 16,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_rand,
    input  logic             req_valid,
    input  logic             req_hit,
    input  logic [SET_W-1:0] req_set,
    input  logic [WAY_W-1:0] req_way,
    input  logic             pred_dead,
    output logic             rsp_valid,
    output logic             rsp_bypass,
    output logic             rsp_alloc,
    output logic [WAY_W-1:0] rsp_way
);
    // Per-line metadata: presence and the single dead-prediction bit
    logic [SETS-1:0][WAYS-1:0] valid_q;
    logic [SETS-1:0][WAYS-1:0] dead_q;
    logic [SET_W-1:0]          rsp_set_q;

    logic [WAYS-1:0] cur_valid, cur_dead;
    assign cur_valid = valid_q[req_set];
    assign cur_dead  = dead_q[req_set];

    op_e op;
    always_comb begin
        if (!req_valid)     op = OP_IDLE;
        else if (req_hit)   op = OP_HIT;
        else if (pred_dead) op = OP_BYPASS;
        else                op = OP_FILL;
    end

    // Candidate searches
    logic             empty_found, dead_found;
    logic [WAY_W-1:0] empty_idx, dead_idx, lru_way;
    logic [LFSR_W-1:0] lfsr_q;

    dbr_first_one #(.N(WAYS)) u_empty (
        .vec   (~cur_valid),
        .found (empty_found),
        .idx   (empty_idx)
    );

    dbr_first_one #(.N(WAYS)) u_dead (
        .vec   (cur_dead & cur_valid),
        .found (dead_found),
        .idx   (dead_idx)
    );

    dbr_lfsr u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .step  (op == OP_FILL || op == OP_BYPASS),
        .state (lfsr_q)
    );

    // Victim priority: empty way, then dead way, then the default policy
    vsrc_e            src;
    logic [WAY_W-1:0] victim;
    always_comb begin
        if (empty_found)     src = SRC_EMPTY;
        else if (dead_found) src = SRC_DEAD;
        else if (mode_rand)  src = SRC_RAND;
        else                 src = SRC_LRU;
        unique case (src)
            SRC_EMPTY: victim = empty_idx;
            SRC_DEAD:  victim = dead_idx;
            SRC_RAND:  victim = lfsr_q[WAY_W-1:0];
            default:   victim = lru_way;
        endcase
    end

    dbr_lru_ranks #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .rd_set    (req_set),
        .touch_en  (op == OP_HIT || op == OP_FILL),
        .touch_set (req_set),
        .touch_way ((op == OP_HIT) ? req_way : victim),
        .lru_way   (lru_way)
    );

    // Metadata update
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dead_q  <= '0;
        end else begin
            unique case (op)
                OP_HIT: begin
                    dead_q[req_set][req_way] <= pred_dead;
                end
                OP_FILL: begin
                    valid_q[req_set][victim] <= 1'b1;
                    dead_q[req_set][victim]  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Registered decision
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_bypass <= 1'b0;
            rsp_alloc  <= 1'b0;
            rsp_way    <= '0;
            rsp_set_q  <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_bypass <= (op == OP_BYPASS);
            rsp_alloc  <= (op == OP_FILL);
            rsp_way    <= (op == OP_FILL) ? victim : '0;
            rsp_set_q  <= req_set;
        end
    end

    // R1: one response per request, one cycle later
    a_r1_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R2: a set with a free way never evicts a valid line
    a_r2_empty_first: assert property (@(posedge clk) disable iff (rst)
        (op == OP_FILL && !(&cur_valid)) |=> rsp_alloc && !$past(cur_valid[victim]));

    // R3: a full set with a dead line evicts a dead line
    a_r3_dead_victim: assert property (@(posedge clk) disable iff (rst)
        (op == OP_FILL && (&cur_valid) && (|cur_dead))
        |=> rsp_alloc && ((($past(cur_dead) >> rsp_way) & WAYS'(1)) != '0));

    // R4: bypass leaves all metadata untouched
    a_r4_bypass_quiet: assert property (@(posedge clk) disable iff (rst)
        op == OP_BYPASS |=> rsp_bypass && !rsp_alloc && $stable(valid_q) && $stable(dead_q));

    // R5: an allocated line is valid and not dead
    a_r5_fill_state: assert property (@(posedge clk) disable iff (rst)
        rsp_alloc |-> valid_q[rsp_set_q][rsp_way] && !dead_q[rsp_set_q][rsp_way]);

    // R6: hit refreshes the dead bit and allocates nothing
    a_r6_hit_update: assert property (@(posedge clk) disable iff (rst)
        op == OP_HIT |=> !rsp_alloc && !rsp_bypass
                         && dead_q[$past(req_set)][$past(req_way)] == $past(pred_dead));

    // R4/R5: the two outcomes of a response exclude each other
    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_bypass, rsp_alloc}));
endmodule

// File: tb/deadblk_repl_bench.sv
module deadblk_repl_bench;
    localparam int SETS  = 4;
    localparam int WAYS  = 16;
    localparam int SET_W = 2;
    localparam int WAY_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode_rand = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_hit = 1'b0;
    logic [SET_W-1:0] req_set = '0;
    logic [WAY_W-1:0] req_way = '0;
    logic             pred_dead = 1'b0;
    logic             rsp_valid, rsp_bypass, rsp_alloc;
    logic [WAY_W-1:0] rsp_way;

    always #4 clk = ~clk;   // 125 MHz

    deadblk_repl #(.SETS(SETS), .WAYS(WAYS)) u_deadblk_repl (
        .clk(clk), .rst(rst), .mode_rand(mode_rand),
        .req_valid(req_valid), .req_hit(req_hit), .req_set(req_set),
        .req_way(req_way), .pred_dead(pred_dead),
        .rsp_valid(rsp_valid), .rsp_bypass(rsp_bypass),
        .rsp_alloc(rsp_alloc), .rsp_way(rsp_way)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit         bypass;
        bit         alloc;
        logic [3:0] way;
        string      tag;
    } exp_t;
    exp_t expq[$];

    // Reference state built from the requirements
    bit [WAYS-1:0] m_valid [SETS];
    bit [WAYS-1:0] m_dead  [SETS];
    int            m_rank  [SETS][WAYS];
    logic [15:0]   m_lfsr;

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            m_valid[s] = '0;
            m_dead[s]  = '0;
            for (int w = 0; w < WAYS; w++) m_rank[s][w] = w;
        end
        m_lfsr = 16'hACE1;
    endtask

    task automatic model_touch(input int s, input int w);
        int r;
        r = m_rank[s][w];
        for (int v = 0; v < WAYS; v++) begin
            if (v == w) m_rank[s][v] = 0;
            else if (m_rank[s][v] < r) m_rank[s][v] = m_rank[s][v] + 1;
        end
    endtask

    function automatic int model_victim(input int s, input bit rnd);
        for (int w = 0; w < WAYS; w++) if (!m_valid[s][w]) return w;
        for (int w = 0; w < WAYS; w++) if (m_dead[s][w]) return w;
        if (rnd) return int'(m_lfsr[3:0]);
        for (int w = 0; w < WAYS; w++) if (m_rank[s][w] == WAYS - 1) return w;
        return 0;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: one request, expected decision pushed to the scoreboard
    task automatic issue(input int s, input bit hit, input int w, input bit pd,
                         input bit rnd, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_hit = hit; req_set = SET_W'(s);
        req_way = WAY_W'(w); pred_dead = pd; mode_rand = rnd;
        e.tag = tag;
        if (hit) begin
            e.bypass = 0; e.alloc = 0; e.way = 0;
            m_dead[s][w] = pd;
            model_touch(s, w);
        end else if (pd) begin
            e.bypass = 1; e.alloc = 0; e.way = 0;
            m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        end else begin
            int v;
            v = model_victim(s, rnd);
            e.bypass = 0; e.alloc = 1; e.way = 4'(v);
            m_valid[s][v] = 1'b1;
            m_dead[s][v]  = 1'b0;
            model_touch(s, v);
            m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        end
        expq.push_back(e);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    // Monitor: compare each response with the oldest expectation
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R1", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(rsp_bypass == e.bypass, e.tag, "bypass", int'(rsp_bypass), int'(e.bypass));
                check(rsp_alloc == e.alloc, e.tag, "alloc", int'(rsp_alloc), int'(e.alloc));
                check(rsp_way == e.way, e.tag, "way", int'(rsp_way), int'(e.way));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10", "rsp_valid after reset", int'(rsp_valid), 0);

        // R10/R2/R5: empty set fills from way 0 upward
        for (int i = 0; i < WAYS; i++) issue(0, 0, 0, 0, 0, "R2");
        // R7: full, nothing dead, oldest way (0) goes first
        issue(0, 0, 0, 0, 0, "R7");
        issue(0, 0, 0, 0, 0, "R7");
        // R6 then R3: mark ways 9 and 5 dead through hits, lowest dead wins
        issue(0, 1, 9, 1, 0, "R6");
        issue(0, 1, 5, 1, 0, "R6");
        issue(0, 0, 0, 0, 0, "R3");
        // R4: bypass changes nothing, next miss still picks dead way 9
        issue(0, 0, 0, 1, 0, "R4");
        issue(0, 0, 0, 1, 1, "R4");
        issue(0, 0, 0, 0, 0, "R3");
        // R5: a refilled way is no longer dead, default policy resumes
        issue(0, 0, 0, 0, 0, "R5");
        // R6: dead bit set then cleared by a later hit
        issue(0, 1, 3, 1, 0, "R6");
        issue(0, 1, 3, 0, 0, "R6");
        issue(0, 0, 0, 0, 0, "R6");
        // R9: other set still empty, starts at way 0
        issue(1, 0, 0, 0, 0, "R9");
        issue(1, 0, 0, 0, 0, "R9");
        issue(0, 0, 0, 0, 0, "R9");
        // R8: random default in a full set; hits do not step the LFSR
        for (int i = 0; i < 6; i++) issue(0, 0, 0, 0, 1, "R8");
        issue(0, 1, 7, 0, 1, "R8");
        for (int i = 0; i < 4; i++) issue(0, 0, 0, 0, 1, "R8");

        // Mixed traffic over all sets and both modes
        for (int i = 0; i < 600; i++) begin
            int s, kind, w;
            bit rnd, pd;
            s    = $urandom_range(0, SETS - 1);
            kind = $urandom_range(0, 9);
            rnd  = $urandom_range(0, 1);
            pd   = ($urandom_range(0, 2) == 0);
            if (kind < 4 && m_valid[s] != '0) begin
                w = $urandom_range(0, WAYS - 1);
                while (!m_valid[s][w]) w = (w + 1) % WAYS;
                issue(s, 1, w, pd, rnd, "R6");
            end else if (kind == 9) begin
                @(negedge clk);   // idle cycle, no response expected (R1)
            end else begin
                issue(s, 0, 0, pd, rnd, pd ? "R4" : (rnd ? "R8" : "R7"));
            end
        end

        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R1", "responses outstanding", expq.size(), 0);
        finish_run();
    end
endmodule